// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side read engine of a parallel memory that answers synchronous burst reads. A host drops the address-valid strobe with chip enable low. The block counts a programmable initial latency and then streams words from an internal word array. Each word stays on the bus for one or two clocks. A WAIT output tells the host when data is not yet ready.

All timing choices come from one 16-bit configuration word, loaded through a write strobe and visible on a read-back port. That word sets the read mode, latency, WAIT polarity and placement, data hold length, output clock edge, burst length and address wrapping. Configurations the block cannot serve are flagged and refused.

Top module: `sync_burst_reader`

## Requirements
- R1: After reset the configuration reads 16'hBF4F, `dqValid` is 0 and `waitOut` is low (inactive for the default active-high polarity).
- R2: A configuration write stores every bit except bits 7, 5 and 4, which always read back as 0.
- R3: When bit 15 is 1 (asynchronous page mode), an address strobe starts no burst: `dqValid` stays 0 and WAIT stays inactive.
- R4: `cfgErr` is 1 in three cases, and no burst starts while it is 1. The cases are: latency code bits 13:11 equal to 000 or 001; length code bits 2:0 not one of 001, 010, 011 or 111; or latency code 010 together with bit 9 = 1 and bit 8 = 1.
- R5: Call E0 the rising edge at which `advN` is sampled low with `ceN` and `oeN` low. The first valid word appears after edge E0+LC, where LC (2 to 7) is the value of bits 13:11.
- R6: The word at address a is {a[7:0] ^ 8'hA5, a[7:0]}. Each word is held for one clock when bit 9 is 0 and for two clocks when bit 9 is 1.
- R7: Bits 2:0 set the burst length: 001 gives 4 words, 010 gives 8 and 011 gives 16, after which `dqValid` drops. 111 streams words without end.
- R8: With bit 3 = 0 and a fixed length, addresses wrap inside the aligned block of that length. With bit 3 = 1, or in continuous mode, addresses count upward modulo 2^ADDR_W.
- R9: WAIT is asserted from E0 until the first valid word when bit 8 is 0. When bit 8 is 1 it is released one data cycle (1 or 2 clocks, per bit 9) earlier.
- R10: Bit 10 sets WAIT polarity: 1 means asserted-high, 0 means asserted-low.
- R11: With bit 6 = 0, data, valid and WAIT change on the falling clock edge, half a cycle after the rising-edge timing used when bit 6 = 1.
- R12: While `ceN` or `oeN` is high, `dqValid` is 0 and WAIT is inactive at once. The burst in progress is ended and does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| advN | input | 1 | Active-low address-valid strobe |
| addr | input | ADDR_W | Start word address |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write value |
| cfgValue | output | 16 | Current configuration word |
| cfgErr | output | 1 | Reserved or unsupported configuration |
| dq | output | 16 | Data word (0 when not valid) |
| dqValid | output | 1 | Data word valid (low models a high-impedance bus) |
| waitOut | output | 1 | WAIT with programmable polarity |

## Verification
A wrong latency counter moves the first valid word and the WAIT release by whole clocks, so the fault shows in the first burst, at the first sample after E0+LC. A corrupt address or hold counter gives a wrong `dq` word, or a word held for the wrong number of cycles. This appears within one or two clocks of the faulty step. Wrong wrap masking shows only when a burst crosses its aligned boundary. A missed abort leaves `dqValid` high, or lets data come back once enable returns, within a cycle.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_DEFAULT    = 16'hBF4F;
  localparam logic [CFG_W-1:0] CFG_FORCE_ZERO = 16'h00B0;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture start address
    logic show;   // present word at current address
    logic step;   // advance address and present that word
    logic clear;  // drop data valid
  } dpCtl_t;

  typedef struct packed {
    logic       readAsync;
    logic [2:0] latCode;
    logic       waitHigh;
    logic       holdTwo;
    logic       waitEarly;
    logic       risingEdge;
    logic       wrapOn;
    logic [2:0] lenCode;
  } rdCfg_t;

  function automatic rdCfg_t decodeCfg(input logic [CFG_W-1:0] w);
    rdCfg_t c;
    c.readAsync  = w[15];
    c.latCode    = w[13:11];
    c.waitHigh   = w[10];
    c.holdTwo    = w[9];
    c.waitEarly  = w[8];
    c.risingEdge = w[6];
    c.wrapOn     = ~w[3];
    c.lenCode    = w[2:0];
    return c;
  endfunction

  // words per burst, 0 = continuous or reserved
  function automatic logic [4:0] lenWords(input logic [2:0] code);
    case (code)
      3'b001:  return 5'd4;
      3'b010:  return 5'd8;
      3'b011:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/sbr_cfg_reg.sv
`timescale 1ns/1ps
module sbr_cfg_reg
  import sbr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfgQ,
  output rdCfg_t           cfg,
  output logic             cfgErr
);
  logic latBad, lenBad, comboBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   cfgQ <= CFG_DEFAULT;
    else if (we) cfgQ <= wdata & ~CFG_FORCE_ZERO;
  end

  assign cfg = decodeCfg(cfgQ);

  always_comb begin
    latBad   = cfg.latCode < 3'd2;
    lenBad   = (lenWords(cfg.lenCode) == 5'd0) && (cfg.lenCode != 3'b111);
    comboBad = (cfg.latCode == 3'd2) && cfg.holdTwo && cfg.waitEarly;
    cfgErr   = latBad | lenBad | comboBad;
  end

  // R2
  cfg_write_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    we |=> (cfgQ == ($past(wdata) & ~CFG_FORCE_ZERO)));
endmodule

// File: rtl/sbr_ctrl.sv
`timescale 1ns/1ps
module sbr_ctrl
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       advN,
  input  logic       readAsync,
  input  logic [2:0] latCode,
  input  logic       holdTwo,
  input  logic       waitEarly,
  input  logic [2:0] lenCode,
  input  logic       cfgErr,
  output dpCtl_t     ctl,
  output logic       waitAssert
);
  seqState_t  state;
  logic [2:0] latCnt;
  logic [1:0] holdLeft;
  logic [4:0] wordCnt;
  logic [4:0] burstLen;
  logic [1:0] holdLen;
  logic [2:0] waitThresh;
  logic       abort, startReq, startOk, wordDone, lastWord;

  always_comb begin
    abort      = ceN | oeN;
    startReq   = ~advN;
    startOk    = ~readAsync & ~cfgErr;
    burstLen   = lenWords(lenCode);
    holdLen    = holdTwo ? 2'd2 : 2'd1;
    wordDone   = (state == ST_DATA) && (holdLeft == 2'd1);
    lastWord   = (burstLen != 5'd0) && (wordCnt == burstLen);
    waitThresh = waitEarly ? {1'b0, holdLen} : 3'd0;
    waitAssert = (state == ST_LAT) && (latCnt > waitThresh);

    ctl.load  = ~abort & startReq & startOk;
    ctl.show  = ~abort & ~startReq & (state == ST_LAT) & (latCnt == 3'd1);
    ctl.step  = ~abort & ~startReq & wordDone & ~lastWord;
    ctl.clear = abort | startReq | (wordDone & lastWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      latCnt   <= '0;
      holdLeft <= '0;
      wordCnt  <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else if (startReq) begin
      if (startOk) begin
        state  <= ST_LAT;
        latCnt <= latCode;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      case (state)
        ST_LAT: begin
          if (latCnt == 3'd1) begin
            state    <= ST_DATA;
            holdLeft <= holdLen;
            wordCnt  <= 5'd1;
          end else begin
            latCnt <= latCnt - 3'd1;
          end
        end
        ST_DATA: begin
          if (holdLeft != 2'd1) begin
            holdLeft <= holdLeft - 2'd1;
          end else if (lastWord) begin
            state <= ST_IDLE;
          end else begin
            holdLeft <= holdLen;
            if (burstLen != 5'd0) wordCnt <= wordCnt + 5'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |=> (state == ST_IDLE));

  // R4
  reject_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !advN && cfgErr) |=> (state == ST_IDLE));

  // R3
  no_async_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !advN && readAsync) |=> (state == ST_IDLE));

  // R6
  hold_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (holdLeft == 2'd1 || holdLeft == 2'd2));
endmodule

// File: rtl/sbr_datapath.sv
`timescale 1ns/1ps
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  dpCtl_t            ctl,
  input  logic              wrapOn,
  input  logic [2:0]        lenCode,
  input  logic              risingEdge,
  input  logic              waitHigh,
  input  logic              waitAssert,
  output logic [15:0]       dq,
  output logic              dqValid,
  output logic              waitOut
);
  logic [ADDR_W-1:0] addrReg, nextAddr, wrapMask;
  logic [15:0]       dqR, dqF, selDq;
  logic              validR, validF, waitF, selValid, selWait, active;

  function automatic logic [15:0] wordOf(input logic [ADDR_W-1:0] a);
    logic [7:0] lo;
    lo = 8'(a);
    return {lo ^ 8'hA5, lo};
  endfunction

  always_comb begin
    case (lenCode)
      3'b001:  wrapMask = ADDR_W'(3);
      3'b010:  wrapMask = ADDR_W'(7);
      3'b011:  wrapMask = ADDR_W'(15);
      default: wrapMask = '1;
    endcase
    if (!wrapOn) wrapMask = '1;
    nextAddr = (addrReg & ~wrapMask) | ((addrReg + ADDR_W'(1)) & wrapMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dqR     <= '0;
      validR  <= 1'b0;
    end else begin
      if (ctl.load) addrReg <= addrIn;
      if (ctl.show) begin
        dqR    <= wordOf(addrReg);
        validR <= 1'b1;
      end else if (ctl.step) begin
        addrReg <= nextAddr;
        dqR     <= wordOf(nextAddr);
        validR  <= 1'b1;
      end else if (ctl.clear) begin
        validR <= 1'b0;
      end
    end
  end

  // half-cycle retimed copy for falling-edge output timing
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      dqF    <= '0;
      validF <= 1'b0;
      waitF  <= 1'b0;
    end else begin
      dqF    <= dqR;
      validF <= validR;
      waitF  <= waitAssert;
    end
  end

  always_comb begin
    active   = ~ceN & ~oeN;
    selDq    = risingEdge ? dqR        : dqF;
    selValid = risingEdge ? validR     : validF;
    selWait  = risingEdge ? waitAssert : waitF;
    dqValid  = active & selValid;
    dq       = dqValid ? selDq : 16'h0000;
    waitOut  = (active & selWait) ^ ~waitHigh;
  end

  // R6
  step_after_show_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> validR);

  // R5
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validR) |-> $past(ctl.show || ctl.step));

  // R8
  wrap_in_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && wrapOn && lenCode == 3'b001)
      |=> (addrReg[ADDR_W-1:2] == $past(addrReg[ADDR_W-1:2])));
endmodule

// File: rtl/sync_burst_reader.sv
`timescale 1ns/1ps
module sync_burst_reader
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfgWe,
  input  logic [15:0]       cfgWdata,
  output logic [15:0]       cfgValue,
  output logic              cfgErr,
  output logic [15:0]       dq,
  output logic              dqValid,
  output logic              waitOut
);
  rdCfg_t cfg;
  dpCtl_t ctl;
  logic   waitAssert;

  sbr_cfg_reg cfg_i (
    .clk(clk), .rstN(rstN), .we(cfgWe), .wdata(cfgWdata),
    .cfgQ(cfgValue), .cfg(cfg), .cfgErr(cfgErr)
  );

  sbr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .advN(advN),
    .readAsync(cfg.readAsync), .latCode(cfg.latCode), .holdTwo(cfg.holdTwo),
    .waitEarly(cfg.waitEarly), .lenCode(cfg.lenCode), .cfgErr(cfgErr),
    .ctl(ctl), .waitAssert(waitAssert)
  );

  sbr_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addrIn(addr), .ctl(ctl),
    .wrapOn(cfg.wrapOn), .lenCode(cfg.lenCode), .risingEdge(cfg.risingEdge),
    .waitHigh(cfg.waitHigh), .waitAssert(waitAssert),
    .dq(dq), .dqValid(dqValid), .waitOut(waitOut)
  );
endmodule

// File: tb/sync_burst_reader_tb_top.sv
`timescale 1ns/1ps
module sync_burst_reader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, advN = 1'b1;
  logic [7:0]  addr = '0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgValue, dq;
  logic        cfgErr, dqValid, waitOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_burst_reader #(.ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .advN(advN), .addr(addr),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgValue(cfgValue), .cfgErr(cfgErr),
    .dq(dq), .dqValid(dqValid), .waitOut(waitOut)
  );

  // {cfg, start addr, cycles, expected valid samples, expected wait samples}
  localparam logic [47:0] VECS [6] = '{
    48'h3F4F_10_11_0B_05,
    48'h1841_06_0A_04_03,
    48'h2642_2D_17_10_04,
    48'h1549_FE_09_04_01,
    48'h2F03_37_28_20_03,
    48'h334A_80_19_10_04
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  // expected outputs for sample k after edge E0+k, from R5..R11
  task automatic model(input logic [15:0] c, input logic [7:0] a0, input int k,
                       output bit eValid, output bit eWait, output logic [15:0] eDq);
    int lc, h, t, bl, kk, idx, m, ea;
    bit wa;
    lc = int'(c[13:11]);
    h  = c[9] ? 2 : 1;
    t  = c[8] ? h : 0;
    case (c[2:0]) 3'b001: bl = 4; 3'b010: bl = 8; 3'b011: bl = 16; default: bl = 0; endcase
    kk = c[6] ? k : k - 1;
    wa = (kk >= 0) && (kk < lc - t);
    eValid = (kk >= lc) && (bl == 0 || (kk - lc) / h < bl);
    idx = (kk >= lc) ? (kk - lc) / h : 0;
    m   = (!c[3] && bl != 0) ? bl - 1 : 255;
    ea  = (int'(a0) & ~m & 255) | ((int'(a0) + idx) & m);
    eDq = {8'(ea) ^ 8'hA5, 8'(ea)};
    eWait = c[10] ? wa : !wa;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check(cfgValue == 16'hBF4F, "R1 cfg reset", cfgValue, 16'hBF4F);
    check(dqValid == 1'b0, "R1 valid reset", dqValid, 0);
    check(waitOut == 1'b0, "R1 wait reset", waitOut, 0);

    // R2 reserved bits forced to zero
    writeCfg(16'hFFFF);
    #2;
    check(cfgValue == 16'hFF4F, "R2 masked write", cfgValue, 16'hFF4F);
    check(cfgErr == 1'b0, "R4 valid cfg no flag", cfgErr, 0);

    // table of bursts: R5..R11
    foreach (VECS[i]) begin
      logic [15:0] c;
      logic [7:0]  a0;
      int n, vCnt, wCnt;
      c = VECS[i][47:32]; a0 = VECS[i][31:24]; n = int'(VECS[i][23:16]);
      vCnt = 0; wCnt = 0;
      writeCfg(c);
      ceN = 1'b0; oeN = 1'b0; advN = 1'b0; addr = a0;
      for (int k = 0; k <= n; k++) begin
        bit eV, eW;
        logic [15:0] eD;
        @(posedge clk); #2;
        if (k == 0) begin
          @(negedge clk); advN = 1'b1;
        end
        model(c, a0, k, eV, eW, eD);
        check(dqValid == eV, "R5/R7 valid timing", dqValid, eV);
        check(waitOut == eW, "R9/R10 wait", waitOut, eW);
        if (eV) check(dq == eD, "R6/R8 data word", dq, eD);
        if (dqValid) vCnt++;
        if (waitOut == c[10]) wCnt++;
      end
      check(vCnt == int'(VECS[i][15:8]), "R7 valid count", vCnt, VECS[i][15:8]);
      check(wCnt == int'(VECS[i][7:0]), "R9 wait count", wCnt, VECS[i][7:0]);
      @(negedge clk); ceN = 1'b1; oeN = 1'b1;
    end
    // R11 specific: vector 5 used falling edge, covered above

    // R3 asynchronous mode: no burst
    writeCfg(16'h9849);
    ceN = 1'b0; oeN = 1'b0; advN = 1'b0; addr = 8'h20;
    @(negedge clk); advN = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #2;
      check(dqValid == 1'b0, "R3 no burst valid", dqValid, 0);
      check(waitOut == 1'b1, "R3 wait inactive", waitOut, 1);
    end
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;

    // R4 reserved latency, reserved length, unsupported combination
    writeCfg(16'h0849); #2;
    check(cfgErr == 1'b1, "R4 reserved latency", cfgErr, 1);
    writeCfg(16'h1844); #2;
    check(cfgErr == 1'b1, "R4 reserved length", cfgErr, 1);
    writeCfg(16'h1249); #2;
    check(cfgErr == 1'b0, "R4 latency 2 late wait ok", cfgErr, 0);
    writeCfg(16'h1349); #2;
    check(cfgErr == 1'b1, "R4 unsupported combo", cfgErr, 1);
    ceN = 1'b0; oeN = 1'b0; advN = 1'b0; addr = 8'h44;
    @(negedge clk); advN = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #2;
      check(dqValid == 1'b0, "R4 rejected burst", dqValid, 0);
    end
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;

    // R12 abort by output enable during a continuous burst
    writeCfg(16'h1847);
    ceN = 1'b0; oeN = 1'b0; advN = 1'b0; addr = 8'h50;
    @(negedge clk); advN = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(dqValid == 1'b1, "R12 burst running", dqValid, 1);
    @(negedge clk); oeN = 1'b1; #1;
    check(dqValid == 1'b0, "R12 valid drops at once", dqValid, 0);
    check(waitOut == 1'b1, "R12 wait inactive", waitOut, 1);
    repeat (2) @(negedge clk);
    oeN = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2;
      check(dqValid == 1'b0, "R12 no resume", dqValid, 0);
      check(waitOut == 1'b1, "R12 wait stays inactive", waitOut, 1);
    end
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule